// File: doc/BRIEF.md
# Banked CPU Address Router

This block sits between an 8-bit CPU with a 16-bit address bus and the memories and register files around it. For every read or write it works out which target the address belongs to: fixed ROM, switched ROM, video RAM, cartridge RAM or its clock registers, work RAM, object attribute RAM, I/O, high RAM or the interrupt-enable register. It raises a one-hot select for that target, forms the target's local address, and returns the target's read data on the CPU read bus. Writes into the ROM range go to the cartridge bank controller as a command strobe instead.

The block owns the work-RAM bank register. The upper 4 KiB window of work RAM and its mirror use this register. While an object-attribute DMA is running, the block hides parts of the address space from the CPU. Object RAM is always hidden. A second window depends on the DMA source and on whether the system is the mono or the colour model. Object RAM is also closed while the video engine is in modes 2 and 3.

The decode path is combinational from address to select, local address and read data. Only the bank register is clocked.

Top module: `cpu_bus_router`

## Requirements
- R1: When no access is blocked, a read of 0x0000–0x3FFF selects fixed ROM (mem_sel bit 0) and a read of 0x4000–0x7FFF selects switched ROM (bit 1). In both cases loc_addr is address[13:0] and cpu_rdata is rom_rdata.
- R2: A write to 0x0000–0x7FFF raises bankctl_wr and leaves mem_sel at zero and mem_wr low.
- R3: For 0xA000–0xBFFF the first matching case applies: a selected clock register gives bit 4 with loc_addr 0; otherwise, when RAM is enabled and present, cartridge RAM gives bit 3 with loc_addr address[12:0]; otherwise nothing is selected and reads return 0xFF. Video RAM at 0x8000–0x9FFF gives bit 2 with loc_addr address[12:0].
- R4: 0xC000–0xCFFF and 0xE000–0xEFFF select work RAM (bit 5) with loc_addr {0, address[11:0]}. 0xD000–0xDFFF and 0xF000–0xFDFF select work RAM with loc_addr {bank, address[11:0]}.
- R5: The bank register resets to 1. A write to 0xFF70 loads data[2:0], except that 0 loads 1. A read of 0xFF70 returns {5'b11111, bank}. An access to 0xFF70 selects no target.
- R6: With no DMA, 0xFE00–0xFE9F selects object RAM (bit 6) with loc_addr address[7:0] only when vid_mode is 0 or 1. Otherwise nothing is selected and reads return 0xFF.
- R7: 0xFEA0–0xFEFF selects nothing and reads 0xFF. 0xFF00–0xFF7F (except 0xFF70) selects I/O (bit 7), and 0xFF80–0xFFFE selects high RAM (bit 8), both with loc_addr address[6:0]. 0xFFFF selects interrupt enable (bit 9).
- R8: While odma_active is high, 0xFE00–0xFE9F is blocked whatever the video mode.
- R9: Mono model (model_color=0) with DMA active: a source in 0x8000–0x9FFF blocks 0x8000–0x9FFF. Any other source blocks 0xA000–0xFDFF.
- R10: Colour model with DMA active: a source in 0x8000–0x9FFF blocks 0x8000–0x9FFF, and a source in 0xC000–0xDFFF blocks 0xC000–0xFDFF. Any other source blocks 0xA000–0xBFFF.
- R11: A blocked access selects nothing and keeps mem_rd and mem_wr low. A blocked read returns 0xFF.
- R12: mem_sel has at most one bit set and is zero when neither cpu_rd nor cpu_wr is high. mem_rd and mem_wr follow cpu_rd and cpu_wr only when a target is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| model_color | input | 1 | 0 = mono conflict table, 1 = colour table; static after reset |
| vid_mode | input | 2 | Current video engine mode |
| odma_active | input | 1 | Object DMA in progress |
| odma_src | input | 16 | Current object DMA source address |
| clkreg_sel | input | 1 | Cartridge clock register mapped into 0xA000 window |
| xram_en | input | 1 | Cartridge RAM access enabled |
| xram_present | input | 1 | Cartridge RAM fitted |
| mem_sel | output | 10 | One-hot target select |
| mem_rd | output | 1 | Read to selected target |
| mem_wr | output | 1 | Write to selected target |
| loc_addr | output | 15 | Target-local address |
| bankctl_wr | output | 1 | Write strobe to bank-controller registers |
| rom_rdata | input | 8 | ROM read data |
| vram_rdata | input | 8 | Video RAM read data |
| xram_rdata | input | 8 | Cartridge RAM read data |
| clkreg_rdata | input | 8 | Clock register read data |
| wram_rdata | input | 8 | Work RAM read data |
| oam_rdata | input | 8 | Object RAM read data |
| io_rdata | input | 8 | I/O read data |
| hram_rdata | input | 8 | High RAM read data |
| ie_rdata | input | 8 | Interrupt-enable read data |

## Verification
The bench focuses on the edges of each conflict window. Colour sources from 0xE000 upward should block only cartridge RAM. A mono source outside video RAM should block work RAM and its mirror. A design with a misindexed table would either expose RAM the DMA is using or stall unrelated accesses. A bank write of zero is tried: it must read back as 1, and a design that stored it as written would alias the upper work-RAM window onto bank 0. Object RAM is probed in every video mode, both with and without DMA. A missing gate would show up as a live select where 0xFF is expected. ROM-range writes must reach only the bank-controller strobe and never a memory select.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int NTGT = 10;

  typedef enum logic [3:0] {
    TG_ROM0 = 4'd0, TG_ROMX = 4'd1, TG_VRAM = 4'd2, TG_XRAM = 4'd3,
    TG_CLK  = 4'd4, TG_WRAM = 4'd5, TG_OAM  = 4'd6, TG_IO   = 4'd7,
    TG_HRAM = 4'd8, TG_IE   = 4'd9, TG_NONE = 4'd15
  } tgt_e;

  localparam logic [15:0] OAM_LO  = 16'hFE00;
  localparam logic [15:0] OAM_HI  = 16'hFEA0;
  localparam logic [15:0] IO_LO   = 16'hFF00;
  localparam logic [15:0] HRAM_LO = 16'hFF80;
  localparam logic [15:0] IE_ADDR = 16'hFFFF;

  // Blocked window selected by the DMA source's top three bits and the model.
  function automatic logic dma_window_hit(logic color, logic [2:0] src_top,
                                          logic [15:0] a);
    logic [15:0] lo, hi;
    if (src_top == 3'd4) begin
      lo = 16'h8000; hi = 16'hA000;
    end else if (color && src_top == 3'd6) begin
      lo = 16'hC000; hi = 16'hFE00;
    end else if (color) begin
      lo = 16'hA000; hi = 16'hC000;
    end else begin
      lo = 16'hA000; hi = 16'hFE00;
    end
    return (a >= lo) && (a < hi);
  endfunction

  function automatic logic in_oam(logic [15:0] a);
    return (a >= OAM_LO) && (a < OAM_HI);
  endfunction
endpackage

// File: rtl/cbr_region_decode.sv
module cbr_region_decode
  import cbr_pkg::*;
#(
  parameter logic [15:0] BANK_ADDR = 16'hFF70
) (
  input  logic [15:0] addr,
  input  logic        clkreg_sel,
  input  logic        xram_ok,
  input  logic        oam_open,
  output tgt_e        tgt
);
  always_comb begin
    tgt = TG_NONE;
    case (addr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: tgt = TG_ROM0;
      4'h4, 4'h5, 4'h6, 4'h7: tgt = TG_ROMX;
      4'h8, 4'h9:             tgt = TG_VRAM;
      4'hA, 4'hB: begin
        if (clkreg_sel)   tgt = TG_CLK;
        else if (xram_ok) tgt = TG_XRAM;
        else              tgt = TG_NONE;
      end
      4'hC, 4'hD, 4'hE:       tgt = TG_WRAM;
      default: begin
        if (addr < OAM_LO)          tgt = TG_WRAM;
        else if (addr < OAM_HI)     tgt = oam_open ? TG_OAM : TG_NONE;
        else if (addr < IO_LO)      tgt = TG_NONE;
        else if (addr == BANK_ADDR) tgt = TG_NONE;
        else if (addr < HRAM_LO)    tgt = TG_IO;
        else if (addr < IE_ADDR)    tgt = TG_HRAM;
        else                        tgt = TG_IE;
      end
    endcase
  end
endmodule

// File: rtl/cbr_dma_guard.sv
module cbr_dma_guard
  import cbr_pkg::*;
(
  input  logic        odma_active,
  input  logic [15:0] odma_src,
  input  logic        model_color,
  input  logic [15:0] addr,
  output logic        blocked
);
  logic oam_hit, win_hit;
  always_comb begin
    oam_hit = in_oam(addr);
    win_hit = dma_window_hit(model_color, odma_src[15:13], addr);
    blocked = odma_active && (oam_hit || win_hit);
  end
endmodule

// File: rtl/cbr_wram_bank.sv
module cbr_wram_bank #(
  parameter int          BANK_W    = 3,
  parameter logic [15:0] BANK_ADDR = 16'hFF70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       addr,
  input  logic [7:0]        wdata,
  output logic [BANK_W-1:0] bank,
  output logic              bank_wr
);
  logic [BANK_W-1:0] req;
  always_comb begin
    bank_wr = cpu_wr && (addr == BANK_ADDR);
    req     = wdata[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank <= BANK_W'(1);
    else if (bank_wr) bank <= (req == '0) ? BANK_W'(1) : req;
  end
endmodule

// File: rtl/cbr_rdata_mux.sv
module cbr_rdata_mux
  import cbr_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              route_ok,
  input  tgt_e              tgt,
  input  logic              bank_rd,
  input  logic [BANK_W-1:0] bank,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        vram_rdata,
  input  logic [7:0]        xram_rdata,
  input  logic [7:0]        clkreg_rdata,
  input  logic [7:0]        wram_rdata,
  input  logic [7:0]        oam_rdata,
  input  logic [7:0]        io_rdata,
  input  logic [7:0]        hram_rdata,
  input  logic [7:0]        ie_rdata,
  output logic [7:0]        rdata
);
  always_comb begin
    rdata = 8'hFF;
    if (bank_rd) begin
      rdata = {{(8-BANK_W){1'b1}}, bank};
    end else if (route_ok) begin
      case (tgt)
        TG_ROM0, TG_ROMX: rdata = rom_rdata;
        TG_VRAM:          rdata = vram_rdata;
        TG_XRAM:          rdata = xram_rdata;
        TG_CLK:           rdata = clkreg_rdata;
        TG_WRAM:          rdata = wram_rdata;
        TG_OAM:           rdata = oam_rdata;
        TG_IO:            rdata = io_rdata;
        TG_HRAM:          rdata = hram_rdata;
        TG_IE:            rdata = ie_rdata;
        default:          rdata = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/cpu_bus_router.sv
module cpu_bus_router
  import cbr_pkg::*;
#(
  parameter int          BANK_W    = 3,
  parameter logic [15:0] BANK_ADDR = 16'hFF70
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cpu_addr,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [7:0]           cpu_wdata,
  output logic [7:0]           cpu_rdata,
  input  logic                 model_color,
  input  logic [1:0]           vid_mode,
  input  logic                 odma_active,
  input  logic [15:0]          odma_src,
  input  logic                 clkreg_sel,
  input  logic                 xram_en,
  input  logic                 xram_present,
  output logic [NTGT-1:0]      mem_sel,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [BANK_W+11:0]   loc_addr,
  output logic                 bankctl_wr,
  input  logic [7:0]           rom_rdata,
  input  logic [7:0]           vram_rdata,
  input  logic [7:0]           xram_rdata,
  input  logic [7:0]           clkreg_rdata,
  input  logic [7:0]           wram_rdata,
  input  logic [7:0]           oam_rdata,
  input  logic [7:0]           io_rdata,
  input  logic [7:0]           hram_rdata,
  input  logic [7:0]           ie_rdata
);
  localparam int LOC_W = BANK_W + 12;

  tgt_e              tgt;
  logic              blocked;
  logic              rom_hit;
  logic              access;
  logic              route_ok;
  logic              bank_wr;
  logic              bank_rd;
  logic [BANK_W-1:0] bank;

  cbr_region_decode #(.BANK_ADDR(BANK_ADDR)) u_dec (
    .addr       (cpu_addr),
    .clkreg_sel (clkreg_sel),
    .xram_ok    (xram_en && xram_present),
    .oam_open   (vid_mode < 2'd2),
    .tgt        (tgt)
  );

  cbr_dma_guard u_guard (
    .odma_active (odma_active),
    .odma_src    (odma_src),
    .model_color (model_color),
    .addr        (cpu_addr),
    .blocked     (blocked)
  );

  cbr_wram_bank #(.BANK_W(BANK_W), .BANK_ADDR(BANK_ADDR)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_wr  (cpu_wr),
    .addr    (cpu_addr),
    .wdata   (cpu_wdata),
    .bank    (bank),
    .bank_wr (bank_wr)
  );

  always_comb begin
    access     = cpu_rd || cpu_wr;
    rom_hit    = (tgt == TG_ROM0) || (tgt == TG_ROMX);
    bankctl_wr = cpu_wr && rom_hit && !blocked;
    route_ok   = access && !blocked && (tgt != TG_NONE) && !(cpu_wr && rom_hit);
    bank_rd    = cpu_rd && (cpu_addr == BANK_ADDR);
    mem_rd     = cpu_rd && route_ok;
    mem_wr     = cpu_wr && route_ok;
  end

  for (genvar g = 0; g < NTGT; g++) begin : g_sel
    assign mem_sel[g] = route_ok && (tgt == tgt_e'(g));
  end

  always_comb begin
    loc_addr = '0;
    case (tgt)
      TG_ROM0, TG_ROMX: loc_addr = LOC_W'(cpu_addr[13:0]);
      TG_VRAM, TG_XRAM: loc_addr = LOC_W'(cpu_addr[12:0]);
      TG_WRAM: loc_addr = cpu_addr[12] ? {bank, cpu_addr[11:0]}
                                       : LOC_W'(cpu_addr[11:0]);
      TG_OAM:           loc_addr = LOC_W'(cpu_addr[7:0]);
      TG_IO, TG_HRAM:   loc_addr = LOC_W'(cpu_addr[6:0]);
      default:          loc_addr = '0;
    endcase
  end

  cbr_rdata_mux #(.BANK_W(BANK_W)) u_mux (
    .route_ok     (route_ok),
    .tgt          (tgt),
    .bank_rd      (bank_rd),
    .bank         (bank),
    .rom_rdata    (rom_rdata),
    .vram_rdata   (vram_rdata),
    .xram_rdata   (xram_rdata),
    .clkreg_rdata (clkreg_rdata),
    .wram_rdata   (wram_rdata),
    .oam_rdata    (oam_rdata),
    .io_rdata     (io_rdata),
    .hram_rdata   (hram_rdata),
    .ie_rdata     (ie_rdata),
    .rdata        (cpu_rdata)
  );
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int BANK_W = 3,
  parameter int NTGT   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [7:0]        cpu_wdata,
  input logic [7:0]        cpu_rdata,
  input logic [1:0]        vid_mode,
  input logic              odma_active,
  input logic [NTGT-1:0]   mem_sel,
  input logic              mem_rd,
  input logic              bankctl_wr,
  input logic              blocked,
  input logic              bank_wr,
  input logic [BANK_W-1:0] bank
);
  logic oam_range;
  assign oam_range = (cpu_addr >= 16'hFE00) && (cpu_addr < 16'hFEA0);

  // R2
  rom_wr_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |-> (bankctl_wr && mem_sel == '0));

  // R5
  bank_zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && cpu_wdata[BANK_W-1:0] == '0) |=> (bank == BANK_W'(1)));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> $stable(bank));

  // R6
  oam_mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oam_range && vid_mode >= 2'd2) |-> (mem_sel == '0 && (!cpu_rd || cpu_rdata == 8'hFF)));

  // R8
  dma_oam_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odma_active && oam_range) |-> (mem_sel == '0));

  // R11
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && cpu_rd) |-> (cpu_rdata == 8'hFF && !mem_rd));

  // R12
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_sel));

  // R12
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |-> (mem_sel == '0));
endmodule

bind cpu_bus_router cbr_checker #(.BANK_W(BANK_W), .NTGT(cbr_pkg::NTGT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_rd      (cpu_rd),
  .cpu_wr      (cpu_wr),
  .cpu_wdata   (cpu_wdata),
  .cpu_rdata   (cpu_rdata),
  .vid_mode    (vid_mode),
  .odma_active (odma_active),
  .mem_sel     (mem_sel),
  .mem_rd      (mem_rd),
  .bankctl_wr  (bankctl_wr),
  .blocked     (blocked),
  .bank_wr     (bank_wr),
  .bank        (bank)
);

// File: tb/sim_cpu_bus_router.sv
module sim_cpu_bus_router;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic        cpu_rd = 0, cpu_wr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [7:0]  cpu_rdata;
  logic        model_color = 0;
  logic [1:0]  vid_mode = 0;
  logic        odma_active = 0;
  logic [15:0] odma_src = 0;
  logic        clkreg_sel = 0, xram_en = 0, xram_present = 0;
  logic [9:0]  mem_sel;
  logic        mem_rd, mem_wr, bankctl_wr;
  logic [14:0] loc_addr;

  localparam logic [7:0] D_ROM = 8'h11, D_VRAM = 8'h22, D_XRAM = 8'h33,
    D_CLK = 8'h44, D_WRAM = 8'h55, D_OAM = 8'h66, D_IO = 8'h77,
    D_HRAM = 8'h88, D_IE = 8'h99;

  cpu_bus_router u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .model_color(model_color), .vid_mode(vid_mode),
    .odma_active(odma_active), .odma_src(odma_src),
    .clkreg_sel(clkreg_sel), .xram_en(xram_en), .xram_present(xram_present),
    .mem_sel(mem_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .loc_addr(loc_addr), .bankctl_wr(bankctl_wr),
    .rom_rdata(D_ROM), .vram_rdata(D_VRAM), .xram_rdata(D_XRAM),
    .clkreg_rdata(D_CLK), .wram_rdata(D_WRAM), .oam_rdata(D_OAM),
    .io_rdata(D_IO), .hram_rdata(D_HRAM), .ie_rdata(D_IE)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int bank_m = 1;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h addr=%04h", req, what, act, exp, cpu_addr);
    end
  endtask

  function automatic bit conflict(bit color, logic [15:0] s, logic [15:0] a);
    bit s_vram = (s >= 16'h8000 && s <= 16'h9FFF);
    if (a >= 16'hFE00 && a <= 16'hFE9F) return 1;
    if (s_vram) return (a >= 16'h8000 && a <= 16'h9FFF);
    if (!color) return (a >= 16'hA000 && a <= 16'hFDFF);
    if (s >= 16'hC000 && s <= 16'hDFFF) return (a >= 16'hC000 && a <= 16'hFDFF);
    return (a >= 16'hA000 && a <= 16'hBFFF);
  endfunction

  function automatic string tag_of(logic [15:0] a, bit blk);
    if (blk) return (a >= 16'hFE00 && a <= 16'hFE9F) ? "R8" : (model_color ? "R10" : "R9");
    if (a < 16'h8000) return "R1";
    if (a < 16'hC000) return "R3";
    if (a < 16'hFE00) return "R4";
    if (a < 16'hFEA0) return "R6";
    if (a == 16'hFF70) return "R5";
    return "R7";
  endfunction

  // Expected target index (-1 = none), local address and read data.
  task automatic op(logic [15:0] a, bit rd, bit wr, logic [7:0] wd);
    int t = -1; int loc = 0; int rdv = 8'hFF; bit bc = 0; bit blk; string tg;
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    if (a <= 16'h3FFF) begin t = 0; loc = a % 16384; rdv = D_ROM; end
    else if (a <= 16'h7FFF) begin t = 1; loc = a % 16384; rdv = D_ROM; end
    else if (a <= 16'h9FFF) begin t = 2; loc = a - 16'h8000; rdv = D_VRAM; end
    else if (a <= 16'hBFFF) begin
      if (clkreg_sel) begin t = 4; loc = 0; rdv = D_CLK; end
      else if (xram_en && xram_present) begin t = 3; loc = a - 16'hA000; rdv = D_XRAM; end
    end
    else if (a <= 16'hFDFF) begin
      t = 5; rdv = D_WRAM;
      loc = ((a >= 16'hD000 && a <= 16'hDFFF) || a >= 16'hF000) ? bank_m * 4096 + a % 4096 : a % 4096;
    end
    else if (a <= 16'hFE9F) begin
      if (vid_mode < 2) begin t = 6; loc = a - 16'hFE00; rdv = D_OAM; end
    end
    else if (a <= 16'hFEFF) t = -1;
    else if (a == 16'hFF70) t = -1;
    else if (a <= 16'hFF7F) begin t = 7; loc = a - 16'hFF00; rdv = D_IO; end
    else if (a <= 16'hFFFE) begin t = 8; loc = a - 16'hFF80; rdv = D_HRAM; end
    else begin t = 9; loc = 0; rdv = D_IE; end
    blk = odma_active && conflict(model_color, odma_src, a);
    if (blk) t = -1;
    if (wr && a <= 16'h7FFF) begin bc = 1; t = -1; end
    if (!rd && !wr) t = -1;
    if (t < 0) rdv = 8'hFF;
    if (a == 16'hFF70) rdv = 8'hF8 | bank_m;
    tg = tag_of(a, blk);
    #1;
    chk(tg, "sel", int'(mem_sel), (t < 0) ? 0 : (1 << t));
    chk(wr && a <= 16'h7FFF ? "R2" : "R12", "bankctl", int'(bankctl_wr), int'(bc));
    chk((t < 0 && !blk) ? "R12" : (blk ? "R11" : tg), "rd_wr",
        int'({mem_rd, mem_wr}), (t < 0) ? 0 : int'({rd, wr}));
    if (t >= 0) chk(tg, "loc", int'(loc_addr), loc);
    if (rd) chk(blk ? "R11" : tg, "rdata", int'(cpu_rdata), rdv);
    if (wr && a == 16'hFF70) bank_m = (wd[2:0] == 0) ? 1 : wd[2:0];
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic do_reset(bit color);
    @(negedge clk);
    rst_n = 0; model_color = color; odma_active = 0; vid_mode = 0;
    clkreg_sel = 0; xram_en = 1; xram_present = 1;
    repeat (2) @(negedge clk);
    rst_n = 1; bank_m = 1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      // R12 idle, R5 reset value
      op(16'hC123, 0, 0, 0);
      op(16'hFF70, 1, 0, 0);
      // R5 zero maps to 1, other values kept
      op(16'hFF70, 0, 1, 8'h00); op(16'hFF70, 1, 0, 0);
      op(16'hFF70, 0, 1, 8'hFE); op(16'hFF70, 1, 0, 0);
      op(16'hD456, 1, 0, 0); op(16'hF456, 0, 1, 8'h5A); op(16'hE456, 1, 0, 0);
      // R2 ROM write goes to bank controller
      op(16'h2100, 0, 1, 8'h03); op(16'h6000, 0, 1, 8'h01);
      op(16'h0150, 1, 0, 0); op(16'h4ABC, 1, 0, 0);
      // R3 priority
      clkreg_sel = 1; op(16'hA000, 1, 0, 0);
      clkreg_sel = 0; xram_en = 0; op(16'hB000, 1, 0, 0);
      xram_en = 1; op(16'hBFFF, 1, 0, 0);
      // R6 mode gating, R7 edges
      vid_mode = 3; op(16'hFE10, 1, 0, 0); op(16'hFE10, 0, 1, 8'h1);
      vid_mode = 1; op(16'hFE9F, 1, 0, 0);
      op(16'hFEA0, 1, 0, 0); op(16'hFF7F, 1, 0, 0); op(16'hFF80, 1, 0, 0);
      op(16'hFFFE, 1, 0, 0); op(16'hFFFF, 1, 0, 0);
      // R8-R10 conflict windows
      odma_active = 1;
      odma_src = 16'hC000; op(16'hE123, 1, 0, 0); op(16'hA010, 1, 0, 0);
      odma_src = 16'h9000; op(16'hC000, 1, 0, 0); op(16'h9FFF, 0, 1, 8'h7);
      odma_src = 16'h0000; op(16'hD000, 1, 0, 0); op(16'hBFFF, 1, 0, 0);
      odma_src = 16'hE000; op(16'hFDFF, 1, 0, 0); op(16'hFE00, 1, 0, 0);
      op(16'hFF80, 1, 0, 0);
      odma_active = 0;
      // random mix
      for (int i = 0; i < 3000; i++) begin
        logic [15:0] a;
        int sel = $urandom % 16;
        int kind = $urandom % 3;
        if (sel == 0) a = 16'hFE00 + 16'($urandom % 256);
        else if (sel == 1) a = 16'hFF70;
        else if (sel == 2) a = 16'hFF00 + 16'($urandom % 256);
        else a = 16'($urandom);
        vid_mode = 2'($urandom);
        odma_active = ($urandom % 3) == 0;
        odma_src = 16'($urandom);
        clkreg_sel = ($urandom % 4) == 0;
        xram_en = $urandom % 2;
        xram_present = ($urandom % 4) != 0;
        op(a, kind == 1, kind == 2, 8'($urandom));
      end
      odma_active = 0;
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule